// File: doc/BRIEF.md
# Memory Copy Program-Verify Retry Sequencer

This block copies a non-volatile memory byte by byte, from a source device to a target device, using one system clock. It steps an address through the whole array. Each address attempt takes a fixed number of clocks, split into two equal halves. In the first half the source is read and the target is programmed: an active-low chip-enable strobe of parameterised width is issued, and the source byte is captured into a holding register on the edge that starts the strobe. In the second half the source idles, the target is read back, and the returned byte is compared with the held byte.

A failed comparison freezes the address, raises a lock and runs the attempt again. The third consecutive failure on one address gives up. The lock drops, the retry count clears, a sticky error flag is set, and the address moves on. When the attempt on the highest address ends, the block raises `done` and drives every control output to its idle value. A new `start` pulse runs the copy again from address zero.

Top module: `eprom_copy_ctrl`

## Requirements
- R1: During and after reset: `prog_n` = 1, both mode outputs = standby (2'b00), `addr` = 0, and `lock`, `mismatch`, `done`, `err` = 0.
- R2: A `start` pulse seen while no copy is running begins a copy at address 0 on the next clock and clears `done` and `err`. A `start` pulse seen during a copy has no effect on the sequence.
- R3: Every attempt lasts 2·H clocks, where H = STROBE_CYC + 2·SETUP_CYC. In the first H clocks `src_mode` = read (2'b01) and `tgt_mode` = program (2'b10). In the last H clocks `src_mode` = standby (2'b00) and `tgt_mode` = verify (2'b11). Attempts follow each other with no gap.
- R4: In each attempt `prog_n` is low for exactly STROBE_CYC consecutive clocks, starting SETUP_CYC clocks into the first half, and it is low at no other time.
- R5: On the edge where `prog_n` falls, `src_data` is captured. `tgt_wdata` shows that byte until the next capture.
- R6: `mismatch` is high only in the verify half, and only while `tgt_data` differs from the held byte. A difference during the program half is ignored.
- R7: A mismatch at the last clock of an attempt, with fewer than MAX_TRIES failures on that address, sets `lock`, keeps `addr` unchanged and starts another attempt.
- R8: The MAX_TRIES-th (3rd) consecutive failure on one address clears `lock` and the retry count, advances `addr` and sets `err`. `err` stays set until the next accepted `start`.
- R9: A match at the last clock of an attempt advances `addr` by one and leaves `lock` low.
- R10: When the attempt on address 2^ADDR_W−1 ends, `done` rises, `addr` stays at that value, `prog_n` is high and both modes are standby until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a copy when idle |
| src_data | input | DATA_W | Byte read from the source device |
| tgt_data | input | DATA_W | Byte read back from the target device |
| tgt_wdata | output | DATA_W | Held byte presented to the target for writing |
| prog_n | output | 1 | Active-low programming strobe to the target chip enable |
| src_mode | output | 2 | Source mode: 00 standby, 01 read |
| tgt_mode | output | 2 | Target mode: 00 standby, 10 program, 11 verify |
| addr | output | ADDR_W | Shared address for both devices |
| lock | output | 1 | Address frozen while a retry is pending |
| mismatch | output | 1 | Verify-half inequality indicator |
| done | output | 1 | Copy finished |
| err | output | 1 | Sticky: some address used up its retries |

## Verification
Retry exhaustion and end-of-array completion can happen on the same clock edge. On that edge the lock must drop, the error flag must set and `done` must rise together, while the address stays at its top value. The first sweep forces this by making the highest address fail on every write. The bench then checks the attempt count on that address, the sticky error, the final address and the total number of active clocks, all against values derived from the failure pattern. A second coincidence, a `start` pulse arriving in the middle of a running copy, is judged by showing that the per-address attempt counts and the total active clock count do not change.

// File: rtl/epc_pkg.sv
package epc_pkg;

  typedef enum logic [1:0] {
    MD_STBY = 2'b00,
    MD_READ = 2'b01,
    MD_PROG = 2'b10,
    MD_VRFY = 2'b11
  } mode_e;

  // clocks in one half of an attempt: margin, strobe, margin
  function automatic int half_len(input int strobe_cyc, input int setup_cyc);
    return strobe_cyc + 2 * setup_cyc;
  endfunction

  // strobe window inside the program half
  function automatic logic in_window(input int pos, input int setup_cyc, input int strobe_cyc);
    return (pos >= setup_cyc) && (pos < setup_cyc + strobe_cyc);
  endfunction

endpackage

// File: rtl/epc_phase_timer.sv
module epc_phase_timer #(
  parameter int STROBE_CYC = 98,
  parameter int SETUP_CYC  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic prog_half,
  output logic strobe_on,
  output logic latch_now,
  output logic cycle_end
);
  localparam int HALF = epc_pkg::half_len(STROBE_CYC, SETUP_CYC);
  localparam int CYC  = 2 * HALF;
  localparam int TW   = $clog2(CYC);

  logic [TW-1:0] tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      tick <= '0;
    else if (!run)                   tick <= '0;
    else if (tick == TW'(CYC - 1))   tick <= '0;
    else                             tick <= tick + 1'b1;
  end

  assign prog_half = run && (tick < TW'(HALF));
  assign strobe_on = run && epc_pkg::in_window(int'(tick), SETUP_CYC, STROBE_CYC);
  assign latch_now = run && (tick == TW'(SETUP_CYC - 1));
  assign cycle_end = run && (tick == TW'(CYC - 1));

  p_tick_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (int'(tick) < CYC));
  p_capture_opens_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_now && run) |=> strobe_on);
endmodule

// File: rtl/epc_retry_ctr.sv
module epc_retry_ctr #(
  parameter int MAX_TRIES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic cycle_end,
  input  logic miss,
  output logic lock,
  output logic exhaust,
  output logic advance
);
  localparam int CW = $clog2(MAX_TRIES + 1);

  logic [CW-1:0] tries;

  assign exhaust = cycle_end && miss && (tries == CW'(MAX_TRIES - 1));
  assign advance = cycle_end && (!miss || exhaust);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tries <= '0;
      lock  <= 1'b0;
    end else if (clear) begin
      tries <= '0;
      lock  <= 1'b0;
    end else if (cycle_end) begin
      tries <= advance ? '0 : tries + 1'b1;
      lock  <= !advance;
    end
  end

  p_tries_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tries) < MAX_TRIES);
  p_release_after_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exhaust && !clear) |=> (!lock && tries == '0));
  p_hold_on_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && miss && !exhaust && !clear) |=> lock);
endmodule

// File: rtl/epc_addr_ctr.sv
module epc_addr_ctr #(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr,
  output logic              at_top
);
  assign at_top = &addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   addr <= '0;
    else if (restart)             addr <= '0;
    else if (advance && !at_top)  addr <= addr + 1'b1;
  end
endmodule

// File: rtl/eprom_copy_ctrl.sv
module eprom_copy_ctrl #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int STROBE_CYC = 98,
  parameter int SETUP_CYC  = 4,
  parameter int MAX_TRIES  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] src_data,
  input  logic [DATA_W-1:0] tgt_data,
  output logic [DATA_W-1:0] tgt_wdata,
  output logic              prog_n,
  output logic [1:0]        src_mode,
  output logic [1:0]        tgt_mode,
  output logic [ADDR_W-1:0] addr,
  output logic              lock,
  output logic              mismatch,
  output logic              done,
  output logic              err
);
  import epc_pkg::*;

  logic run, start_go;
  logic prog_half, strobe_on, latch_now, cycle_end;
  logic exhaust, advance, at_top, differs;
  logic [DATA_W-1:0] held;

  assign start_go = start && !run;

  epc_phase_timer #(.STROBE_CYC(STROBE_CYC), .SETUP_CYC(SETUP_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run),
    .prog_half(prog_half), .strobe_on(strobe_on),
    .latch_now(latch_now), .cycle_end(cycle_end)
  );

  epc_retry_ctr #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk(clk), .rst_n(rst_n), .clear(start_go),
    .cycle_end(cycle_end), .miss(differs),
    .lock(lock), .exhaust(exhaust), .advance(advance)
  );

  epc_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .restart(start_go),
    .advance(advance), .addr(addr), .at_top(at_top)
  );

  // holding register, loaded on the edge that opens the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held <= '0;
    else if (latch_now) held <= src_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else if (start_go) begin
      run  <= 1'b1;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (advance && at_top) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
      if (exhaust) err <= 1'b1;
    end
  end

  assign differs   = (tgt_data != held);
  assign mismatch  = run && !prog_half && differs;
  assign tgt_wdata = held;
  assign prog_n    = !strobe_on;

  always_comb begin
    src_mode = MD_STBY;
    tgt_mode = MD_STBY;
    if (run) begin
      src_mode = prog_half ? MD_READ : MD_STBY;
      tgt_mode = prog_half ? MD_PROG : MD_VRFY;
    end
  end

  p_strobe_in_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> (tgt_mode == MD_PROG && src_mode == MD_READ));
  p_flag_verify_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |-> (tgt_mode == MD_VRFY));
  p_addr_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && !cycle_end && !start_go) |=> $stable(addr));
  p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prog_n && src_mode == MD_STBY && tgt_mode == MD_STBY && !lock));
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (!done && !err && addr == '0));
endmodule

// File: tb/tb_eprom_copy_ctrl.sv
`timescale 1ns/1ps
module tb_eprom_copy_ctrl;
  localparam int AW = 3, DW = 8, SB = 3, SU = 1, MT = 3;
  localparam int HALF = SB + 2 * SU;
  localparam int CYC = 2 * HALF;
  localparam int NA = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [DW-1:0] src_data, tgt_data, tgt_wdata;
  logic prog_n, lock, mismatch, done, err;
  logic [1:0] src_mode, tgt_mode;
  logic [AW-1:0] addr;

  int total = 0, bad = 0, seed = 0;
  logic [DW-1:0] tgt_mem [NA];
  int fails [NA];
  int tries [NA];
  int active = 0, low_len = 0;
  int v3 = 0, v4 = 0, v5 = 0, v6 = 0, v7 = 0;
  logic prev_n = 1'b1;

  always #2 clk = ~clk;

  eprom_copy_ctrl #(.ADDR_W(AW), .DATA_W(DW), .STROBE_CYC(SB), .SETUP_CYC(SU), .MAX_TRIES(MT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_data(src_data), .tgt_data(tgt_data),
    .tgt_wdata(tgt_wdata), .prog_n(prog_n), .src_mode(src_mode), .tgt_mode(tgt_mode),
    .addr(addr), .lock(lock), .mismatch(mismatch), .done(done), .err(err)
  );

  function automatic logic [DW-1:0] src_of(input int a, input int s);
    return DW'(a * 37 + 5 + s);
  endfunction

  assign src_data = src_of(int'(addr), seed);
  // program half: drive a deliberately different byte so inequality is present
  assign tgt_data = (tgt_mode == 2'b11) ? tgt_mem[addr] : ~tgt_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // target device model and cycle-level observers
  always @(negedge clk) begin
    if (src_mode != 2'b00 || tgt_mode != 2'b00) begin
      int pos;
      logic exp_low, exp_mis;
      pos = active % CYC;
      if (src_mode != ((pos < HALF) ? 2'b01 : 2'b00)) v3++;
      if (tgt_mode != ((pos < HALF) ? 2'b10 : 2'b11)) v3++;
      exp_low = (pos >= SU) && (pos < SU + SB);
      if (prog_n == exp_low) v4++;
      if (!prog_n && prev_n) begin
        int a;
        a = int'(addr);
        tries[a]++;
        if (tgt_wdata != src_of(a, seed)) v5++;
        if (lock != (tries[a] > 1)) v7++;
        tgt_mem[a] = (tries[a] > fails[a]) ? tgt_wdata : (tgt_wdata ^ 8'h01);
      end
      exp_mis = (tgt_mode == 2'b11) && (tgt_mem[addr] != tgt_wdata);
      if (mismatch != exp_mis) v6++;
      active++;
    end else if (mismatch || !prog_n) v6++;
    if (!prog_n) low_len++;
    else if (low_len != 0) begin
      if (low_len != SB) v4++;
      low_len = 0;
    end
    prev_n = prog_n;
  end

  task automatic run_copy(input int pat, input int sd, input bit poke);
    int exp_cyc, n_err;
    bit done_seen;
    seed = sd; active = 0; v3 = 0; v4 = 0; v5 = 0; v6 = 0; v7 = 0;
    exp_cyc = 0; n_err = 0;
    for (int a = 0; a < NA; a++) begin
      tgt_mem[a] = 8'hFF;
      tries[a] = 0;
      case (pat)
        0: fails[a] = (a == NA - 1) ? 3 : (a % 5);
        1: fails[a] = 0;
        default: fails[a] = 2;
      endcase
      exp_cyc += CYC * ((fails[a] < MT) ? fails[a] + 1 : MT);
      if (fails[a] >= MT) n_err++;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!done && !err && addr == '0, "R2 start clears flags, address 0", {done, err}, 0);
    if (poke) begin
      repeat (35) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    done_seen = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (done) begin done_seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(done_seen, "R10 done reached (watchdog)", done_seen, 1);
    chk(v3 == 0, "R3 mode sequence", v3, 0);
    chk(v4 == 0, "R4 strobe window and width", v4, 0);
    chk(v5 == 0, "R5 held byte equals source byte", v5, 0);
    chk(v6 == 0, "R6 mismatch only in verify half", v6, 0);
    chk(v7 == 0, "R7 lock during retries", v7, 0);
    chk(active == exp_cyc, poke ? "R2 mid-run start ignored (active clocks)" : "R9 active clocks",
        active, exp_cyc);
    for (int a = 0; a < NA; a++) begin
      int ea;
      ea = (fails[a] < MT) ? fails[a] + 1 : MT;
      chk(tries[a] == ea, (fails[a] >= MT) ? "R8 attempts at exhausted address" : "R7 attempts per address",
          tries[a], ea);
      chk((tgt_mem[a] == src_of(a, seed)) == (fails[a] < MT), "R9 target content", tgt_mem[a], src_of(a, seed));
    end
    chk(err == (n_err != 0), "R8 sticky error flag", err, n_err != 0);
    repeat (5) @(negedge clk);
    chk(done && addr == AW'(NA - 1), "R10 done held, address at top", int'(addr), NA - 1);
    chk(prog_n && src_mode == 2'b00 && tgt_mode == 2'b00 && !lock, "R10 outputs idle after done",
        {prog_n, src_mode, tgt_mode, lock}, 6'b100000);
  endtask

  initial begin
    #600000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(prog_n && src_mode == 2'b00 && tgt_mode == 2'b00 && addr == '0 && !lock && !mismatch && !done && !err,
        "R1 reset state", {prog_n, lock, done, err}, 4'b1000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(prog_n && !done && !err && addr == '0, "R1 idle after reset", {prog_n, done, err}, 3'b100);
    run_copy(0, 11, 1'b0);   // last address exhausts: error and done on one edge
    run_copy(1, 90, 1'b1);   // clean copy with a stray start in the middle
    run_copy(2, 201, 1'b0);  // two failures everywhere, recovered on third try
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule